// File: doc/BRIEF.md
# Serial channel interrupt generator

This block turns the transmit and receive status of one serial channel into two interrupt conditions and a single active-high interrupt pin. It supports two ways of running the channel. With the FIFOs bypassed, a single holding register on each side sets the conditions. With the FIFOs in use, each FIFO's occupancy is compared with its programmed trigger level. A source-select bit decides whether the transmit condition means "the holding stage can take data" or "the whole transmitter, shifter included, has gone idle".

Each condition is gated by its own enable bit. The gated conditions are ORed into a registered pin. Two line-status flags are also produced: one says the transmit path can accept another byte, and the other says the transmitter is completely empty. The block-mode bit is accepted for completeness. It changes only the ready outputs that sit elsewhere, and it has no effect on anything produced here.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifo_en`=0, `rx_irq` equals `rx_avail`.
- R2: With `fifo_en`=0 and `tx_src`=0, `tx_irq` is 1 exactly when `thr_full` is 0.
- R3: With `fifo_en`=0 and `tx_src`=1, `tx_irq` is 1 exactly when `thr_full` and `tsr_busy` are both 0.
- R4: With `fifo_en`=1, `rx_irq` is 1 exactly when `rx_cnt` >= `rx_trig` and `rx_cnt` is non-zero. `rx_avail` is ignored.
- R5: With `fifo_en`=1 and `tx_src`=0, `tx_irq` is 1 exactly when `tx_cnt` < `tx_trig` or `tx_cnt`=0. `thr_full` is ignored.
- R6: With `fifo_en`=1 and `tx_src`=1, `tx_irq` is 1 exactly when `tx_cnt` < `tx_trig`, or when `tx_cnt`=0 and `tsr_busy`=0.
- R7: `blk_mode` has no effect on any output.
- R8: `tx_room` is `tx_cnt` < DEPTH when `fifo_en`=1, and `!thr_full` when `fifo_en`=0.
- R9: `tx_empty` is 1 exactly when the holding stage is empty and `tsr_busy` is 0. The holding stage is empty when `tx_cnt`=0 (FIFO mode) or when `thr_full`=0 (FIFOs bypassed).
- R10: A cycle with `ie_load`=1 copies `ie_val` into `ie_mask`. Bit 0 enables receive and bit 1 enables transmit. `irq` is registered: after each clock it holds (`rx_irq`&`ie_mask[0]`) | (`tx_irq`&`ie_mask[1]`) as sampled at that edge.
- R11: A clock edge with `rst_n` low clears `ie_mask` to 0 and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs in use |
| blk_mode | input | 1 | Block transfer mode (no effect here) |
| tx_src | input | 1 | Transmit source: 0 holding stage, 1 whole transmitter |
| rx_cnt | input | CW | Receive FIFO occupancy |
| rx_trig | input | CW | Receive trigger level |
| tx_cnt | input | CW | Transmit FIFO occupancy |
| tx_trig | input | CW | Transmit trigger level |
| thr_full | input | 1 | Holding register full (FIFOs bypassed) |
| tsr_busy | input | 1 | Transmit shifter busy |
| rx_avail | input | 1 | Received byte held (FIFOs bypassed) |
| ie_load | input | 1 | Load strobe for the enable mask |
| ie_val | input | 2 | New enable mask |
| rx_irq | output | 1 | Receive interrupt condition |
| tx_irq | output | 1 | Transmit interrupt condition |
| ie_mask | output | 2 | Current enable mask |
| irq | output | 1 | Registered interrupt pin |
| tx_room | output | 1 | Transmit path can accept data |
| tx_empty | output | 1 | Transmitter fully empty |

## Verification
The hardest case to reach is the transmit condition in FIFO mode with the trigger level at zero. Only in that case do the two source-select settings give different results, and the difference depends on whether the shifter is busy while the FIFO is empty. The stimulus table holds that pair of vectors on purpose. It also holds counts at the full depth and trigger equal to count, which exercise the at-or-above boundary. Mask gating and reset are driven as directed sequences, and the registered pin is sampled one edge later.

// File: rtl/uart_irq_pkg.sv
// Shared definitions for the serial channel interrupt generator.
// Assumes: the enable mask bit positions below are the software-visible order.
package uart_irq_pkg;
    typedef enum logic {
        TXSRC_HOLD  = 1'b0,
        TXSRC_SHIFT = 1'b1
    } tx_src_e;

    localparam int IE_W  = 2;
    localparam int IE_RX = 0;
    localparam int IE_TX = 1;
endpackage

// File: rtl/uart_irq_rx_eval.sv
// Receive condition evaluator.
// Computes the receive interrupt condition in either the bypassed mode or the FIFO mode.
// Assumes: a trigger level of zero never fires on an empty FIFO.
module uart_irq_rx_eval #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_avail,
    output logic          rx_cond
);
    logic at_trig;
    logic nonempty;

    // Compare the occupancy with the trigger level; an empty FIFO never counts.
    always_comb begin
        nonempty = (rx_cnt != '0);
        at_trig  = (rx_cnt >= rx_trig) && nonempty;
    end

    // Pick the source for the current mode.
    always_comb begin
        rx_cond = fifo_en ? at_trig : rx_avail;
    end

    // R4
    empty_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_cnt == '0) |-> !rx_cond);
    // R1
    bypass_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_avail) |-> rx_cond);
endmodule

// File: rtl/uart_irq_tx_eval.sv
// Transmit condition evaluator and line-status flags.
// Produces the transmit interrupt condition, the "room" flag and the "fully empty" flag.
// Assumes: thr_full is meaningful only when the FIFOs are bypassed.
module uart_irq_tx_eval #(
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_en,
    input  uart_irq_pkg::tx_src_e tx_src,
    input  logic [CW-1:0]        tx_cnt,
    input  logic [CW-1:0]        tx_trig,
    input  logic                 thr_full,
    input  logic                 tsr_busy,
    output logic                 tx_cond,
    output logic                 room,
    output logic                 all_empty
);
    import uart_irq_pkg::*;

    localparam logic [CW:0] DEPTH_V = (CW+1)'(DEPTH);

    logic hold_empty;
    logic below_trig;

    // Find out whether the holding stage is empty and whether it can accept data.
    always_comb begin
        hold_empty = fifo_en ? (tx_cnt == '0) : !thr_full;
        room       = fifo_en ? ({1'b0, tx_cnt} < DEPTH_V) : !thr_full;
        all_empty  = hold_empty && !tsr_busy;
    end

    // Compare the occupancy with the trigger level.
    always_comb begin
        below_trig = fifo_en && (tx_cnt < tx_trig);
    end

    // Apply the source select to form the transmit condition.
    always_comb begin
        if (tx_src == TXSRC_SHIFT) tx_cond = below_trig || all_empty;
        else                       tx_cond = below_trig || hold_empty;
    end

    // R9
    empty_implies_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> room);
    // R3
    shift_src_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_src == TXSRC_SHIFT && tsr_busy) |-> !tx_cond);
endmodule

// File: rtl/uart_irq_pin_reg.sv
// Enable mask register and registered interrupt pin.
// Assumes: synchronous active-low reset; the mask loads on ie_load.
module uart_irq_pin_reg #(
    parameter int IE_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_load,
    input  logic [IE_W-1:0] ie_val,
    input  logic [IE_W-1:0] cond,
    output logic [IE_W-1:0] mask,
    output logic            pin
);
    // Hold the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (ie_load) mask <= ie_val;
    end

    // Register the OR of the gated conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= |(cond & mask);
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mask == '0 && !pin));
    // R10
    gated_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cond & mask)) |=> pin);
    // R10
    gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(cond & mask)) |=> !pin);
endmodule

// File: rtl/uart_irq_gen.sv
// Serial channel interrupt generator (top).
// Joins the receive and transmit evaluators with the mask and pin register.
// Assumes: blk_mode steers only ready outputs built elsewhere, so it is not used here.
module uart_irq_gen #(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          blk_mode,
    input  logic          tx_src,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] rx_trig,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] tx_trig,
    input  logic          thr_full,
    input  logic          tsr_busy,
    input  logic          rx_avail,
    input  logic          ie_load,
    input  logic [1:0]    ie_val,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic [1:0]    ie_mask,
    output logic          irq,
    output logic          tx_room,
    output logic          tx_empty
);
    import uart_irq_pkg::*;

    logic [IE_W-1:0] cond;

    uart_irq_rx_eval #(.CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .rx_cnt(rx_cnt), .rx_trig(rx_trig), .rx_avail(rx_avail),
        .rx_cond(rx_irq)
    );

    uart_irq_tx_eval #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_src(tx_src_e'(tx_src)), .tx_cnt(tx_cnt), .tx_trig(tx_trig),
        .thr_full(thr_full), .tsr_busy(tsr_busy),
        .tx_cond(tx_irq), .room(tx_room), .all_empty(tx_empty)
    );

    // Place the conditions in mask order.
    always_comb begin
        cond        = '0;
        cond[IE_RX] = rx_irq;
        cond[IE_TX] = tx_irq;
    end

    uart_irq_pin_reg #(.IE_W(IE_W)) u_pin (
        .clk(clk), .rst_n(rst_n), .ie_load(ie_load), .ie_val(ie_val),
        .cond(cond), .mask(ie_mask), .pin(irq)
    );

    // R7
    blk_mode_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(blk_mode) && $stable(cond) && $stable(ie_mask)) |=> $stable(irq));
endmodule

// File: tb/tb_uart_irq_gen.sv
`timescale 1ns/1ps
module tb_uart_irq_gen;
    typedef struct packed {
        logic fe, sel, blk;
        logic [7:0] rxc, rxt, txc, txt;
        logic thf, bsy, av;
        logic erx, etx, eroom, eemp;
    } vec_t;

    localparam int NV = 15;
    // fe sel blk rxc rxt txc txt thf bsy av | rx tx room empty
    localparam vec_t VECS [NV] = '{
        '{0,0,0,  0,  0,  0,  0, 0,0,0, 0,1,1,1},  // R1 R2
        '{0,0,0,  0,  0,  0,  0, 1,0,1, 1,0,0,0},  // R1 R2 R8
        '{0,0,0,  0,  0,  0,  0, 0,1,0, 0,1,1,0},  // R2 R9
        '{0,1,0,  0,  0,  0,  0, 0,1,0, 0,0,1,0},  // R3
        '{0,1,0,  0,  0,  0,  0, 0,0,1, 1,1,1,1},  // R3
        '{0,1,0,  0,  0,  0,  0, 1,0,0, 0,0,0,0},  // R3
        '{1,0,0,  3,  4,  8,  4, 1,1,1, 0,0,1,0},  // R4 R5
        '{1,0,0,  4,  4,  3,  4, 0,1,0, 1,1,1,0},  // R4 R5
        '{1,0,0,  0,  0,  0,  0, 0,1,0, 0,1,1,0},  // R5 zero trigger
        '{1,1,0,  0,  0,  0,  0, 0,1,0, 0,0,1,0},  // R6 zero trigger busy
        '{1,1,0,  0,  0,  0,  0, 0,0,0, 0,1,1,1},  // R6 R9
        '{1,1,0,128,128,128,128, 0,0,0, 1,0,0,0},  // R4 R8 full
        '{1,1,1,128,128,128,128, 0,0,0, 1,0,0,0},  // R7
        '{0,0,1,  0,  0,  0,  0, 1,0,1, 1,0,0,0},  // R7
        '{1,1,0,  5,  4,  2,  4, 0,0,0, 1,1,1,0}   // R4 R6
    };

    logic clk = 0, rst_n = 0;
    logic fifo_en = 0, blk_mode = 0, tx_src = 0;
    logic [7:0] rx_cnt = 0, rx_trig = 0, tx_cnt = 0, tx_trig = 0;
    logic thr_full = 0, tsr_busy = 0, rx_avail = 0, ie_load = 0;
    logic [1:0] ie_val = 0;
    logic rx_irq, tx_irq, irq, tx_room, tx_empty;
    logic [1:0] ie_mask;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    uart_irq_gen dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
        .tx_src(tx_src), .rx_cnt(rx_cnt), .rx_trig(rx_trig), .tx_cnt(tx_cnt),
        .tx_trig(tx_trig), .thr_full(thr_full), .tsr_busy(tsr_busy),
        .rx_avail(rx_avail), .ie_load(ie_load), .ie_val(ie_val),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .ie_mask(ie_mask), .irq(irq),
        .tx_room(tx_room), .tx_empty(tx_empty)
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        fifo_en = v.fe; tx_src = v.sel; blk_mode = v.blk;
        rx_cnt = v.rxc; rx_trig = v.rxt; tx_cnt = v.txc; tx_trig = v.txt;
        thr_full = v.thf; tsr_busy = v.bsy; rx_avail = v.av;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 mask", ie_mask, 0);
        check("R11 irq", irq, 0);
        rst_n = 1;
        ie_load = 1; ie_val = 2'b11;
        @(negedge clk);
        ie_load = 0;
        check("R10 mask load", ie_mask, 3);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            #1;
            check($sformatf("R1-6 rx vec%0d", i), rx_irq, VECS[i].erx);
            check($sformatf("tx vec%0d", i), tx_irq, VECS[i].etx);
            check($sformatf("R8 room vec%0d", i), tx_room, VECS[i].eroom);
            check($sformatf("R9 empty vec%0d", i), tx_empty, VECS[i].eemp);
            @(negedge clk);
            check($sformatf("R10 irq vec%0d", i), irq, VECS[i].erx | VECS[i].etx);
        end

        // R10: receive-only mask, transmit condition active, receive idle
        apply(VECS[0]);
        ie_load = 1; ie_val = 2'b01;
        @(negedge clk); ie_load = 0;
        @(negedge clk);
        check("R10 tx masked", irq, 0);
        apply(VECS[1]);
        @(negedge clk);
        check("R10 rx enabled", irq, 1);
        // R10: transmit-only mask with the same receive condition
        ie_load = 1; ie_val = 2'b10;
        @(negedge clk); ie_load = 0;
        @(negedge clk);
        check("R10 rx masked", irq, 0);

        // R11: reset in the middle of a run with the pin high
        ie_load = 1; ie_val = 2'b11;
        @(negedge clk); ie_load = 0;
        @(negedge clk);
        check("R11 pre", irq, 1);
        rst_n = 0;
        @(negedge clk);
        check("R11 mask cleared", ie_mask, 0);
        check("R11 irq cleared", irq, 0);
        rst_n = 1;
        @(negedge clk);
        check("R11 stays low", irq, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule